// File: doc/BRIEF.md
# Stuck-at Fault Mask Overlay

This block places permanent stuck-at faults on the values a processor core sees, without touching the stored values themselves. It sits between the register storage and the logic that consumes register contents. Every fault site holds a pair of masks. The stuck-at-0 mask marks a faulted bit with a 0 and holds a 1 elsewhere. The stuck-at-1 mask marks a faulted bit with a 1 and holds a 0 elsewhere. A consumer sees the stored value ANDed with the first mask, and that result ORed with the second. Any number of bits may be faulted at once.

There are three fault sites. The first is a bank of general registers on a combinational read path; the slot that holds the program counter is never faulted. The second is the instruction word. It arrives one byte per fetch beat, and each byte gets its own 8-bit slice of the instruction masks in fetch order. The third is the status-flag register. When an instruction completes, its flags are read, masked and presented for write-back. A single write port loads the masks, and software-free fault campaigns drive that port.

Top module: `sa_fault_overlay`

## Requirements
- R1: After reset every stuck-at-0 mask is all ones and every stuck-at-1 mask is all zeros. With these neutral masks, `rd_val` equals `rd_raw`, `out_byte` equals `fetch_byte` and `flag_wb` equals the committed flags, bit for bit.
- R2: `rd_val` is combinationally `(rd_raw & SA0[rd_idx]) | SA1[rd_idx]`, where SA0 and SA1 are the two masks of the selected general register.
- R3: A bit marked in both masks of one site reads as 1.
- R4: A mask write takes effect from the cycle after the clock edge on which `cfg_we` is high. `cfg_target` selects the site: 0 to NUM_REGS-1 are general registers, NUM_REGS is the instruction masks and NUM_REGS+1 is the flag masks. `cfg_kind` selects the mask: 0 is stuck-at-0 and 1 is stuck-at-1. No other mask changes.
- R5: Register slot PC_IDX (default 7) is never faulted. Writes that target it have no effect, and it always reads back its raw value.
- R6: A fetch beat (`fetch_valid` high) with `fetch_sop` high is byte 0 of an instruction. The k-th byte of an instruction, counted from 0, gets bits [8k+7:8k] of the instruction masks. `out_byte` and `out_valid` follow in the same cycle.
- R7: The byte position advances once per valid beat and saturates after byte INSN_BYTES-1 (default 3). Later bytes pass unchanged until the next start-of-instruction beat, which restarts at byte 0 even in the middle of a stream.
- R8: A cycle with `flag_commit` high gives `flag_wb_en` high on the next cycle. On that cycle `flag_wb` equals `(flag_rd & FSA0) | FSA1`, using the flag masks as they stood at the commit edge. `flag_wb_en` is low otherwise.
- R9: A write whose `cfg_target` is above NUM_REGS+1 changes no mask.
- R10: Several faulted bits of different polarity in one mask pair act together in a single read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_target | input | TGT_W (4) | Fault site selector |
| cfg_kind | input | 1 | 0 = stuck-at-0 mask, 1 = stuck-at-1 mask |
| cfg_value | input | CFG_W (32) | Mask value to load |
| rd_idx | input | RIDX_W (3) | Register being read |
| rd_raw | input | REG_W (32) | Stored register value |
| rd_val | output | REG_W (32) | Faulted register value |
| fetch_valid | input | 1 | Fetch byte present |
| fetch_sop | input | 1 | Byte is first of an instruction |
| fetch_byte | input | 8 | Fetched instruction byte |
| out_valid | output | 1 | Faulted byte present |
| out_byte | output | 8 | Faulted instruction byte |
| flag_commit | input | 1 | Instruction completed; flags to write back |
| flag_rd | input | FLAG_W (32) | Flags read after the instruction |
| flag_wb_en | output | 1 | Faulted flag write-back strobe |
| flag_wb | output | FLAG_W (32) | Faulted flags to write back |

## Verification
A corrupted mask register shows up at once, on the combinational read or fetch path, the first time its site is selected. A lost write shows up one cycle after the write edge. A wrong byte position is subtler. It only appears when the instruction masks differ between byte lanes, and only on the first byte that is read at the wrong position. For that reason the streams use lane-distinct masks, and restarts come mid-stream. A flag-path fault appears one cycle after the commit, on the registered write-back.

// File: rtl/sa_fault_pkg.sv
package sa_fault_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    MASK_SA0 = 1'b0,
    MASK_SA1 = 1'b1
  } mask_kind_e;
endpackage

// File: rtl/sa_mask_slot.sv
module sa_mask_slot
  import sa_fault_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         kind,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sa0_q,
  output logic [W-1:0] sa1_q
);
  logic [W-1:0] sa0_d, sa1_d;

  always_comb begin
    sa0_d = sa0_q;
    sa1_d = sa1_q;
    if (mask_kind_e'(kind) == MASK_SA0) sa0_d = wdata;
    else                                sa1_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa0_q <= '1;
      sa1_q <= '0;
    end else if (wr_en) begin
      sa0_q <= sa0_d;
      sa1_q <= sa1_d;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(sa0_q) && $stable(sa1_q))); // R4
endmodule

// File: rtl/sa_fetch_lane.sv
module sa_fetch_lane
  import sa_fault_pkg::*;
#(
  parameter int INSN_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fetch_valid,
  input  logic                         fetch_sop,
  input  logic [BYTE_W-1:0]            fetch_byte,
  input  logic [INSN_BYTES*BYTE_W-1:0] ir_sa0,
  input  logic [INSN_BYTES*BYTE_W-1:0] ir_sa1,
  output logic                         out_valid,
  output logic [BYTE_W-1:0]            out_byte
);
  localparam int IDX_W = $clog2(INSN_BYTES + 1);
  localparam logic [IDX_W-1:0] SAT = IDX_W'(INSN_BYTES);

  logic [IDX_W-1:0]  idx_q, idx_d, cur_idx;
  logic [BYTE_W-1:0] lane_sa0, lane_sa1;

  always_comb begin
    cur_idx  = fetch_sop ? '0 : idx_q;
    lane_sa0 = '1;
    lane_sa1 = '0;
    for (int k = 0; k < INSN_BYTES; k++) begin
      if (cur_idx == IDX_W'(k)) begin
        lane_sa0 = ir_sa0[k*BYTE_W +: BYTE_W];
        lane_sa1 = ir_sa1[k*BYTE_W +: BYTE_W];
      end
    end
    idx_d = (cur_idx == SAT) ? SAT : cur_idx + IDX_W'(1);
  end

  assign out_valid = fetch_valid;
  assign out_byte  = (fetch_byte & lane_sa0) | lane_sa1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           idx_q <= '0;
    else if (fetch_valid) idx_q <= idx_d;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= SAT); // R7
  AST_SOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_sop) |=> (idx_q == IDX_W'(1))); // R6
  AST_IDX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_sop && idx_q == SAT) |=> (idx_q == SAT)); // R7
endmodule

// File: rtl/sa_fault_overlay.sv
module sa_fault_overlay
  import sa_fault_pkg::*;
#(
  parameter int NUM_REGS   = 8,
  parameter int REG_W      = 32,
  parameter int PC_IDX     = 7,
  parameter int INSN_BYTES = 4,
  parameter int FLAG_W     = 32,
  localparam int INSN_W    = INSN_BYTES * BYTE_W,
  localparam int CFG_W     = (REG_W > INSN_W) ? ((REG_W > FLAG_W) ? REG_W : FLAG_W)
                                              : ((INSN_W > FLAG_W) ? INSN_W : FLAG_W),
  localparam int TGT_W     = $clog2(NUM_REGS + 2),
  localparam int RIDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TGT_W-1:0]  cfg_target,
  input  logic              cfg_kind,
  input  logic [CFG_W-1:0]  cfg_value,
  input  logic [RIDX_W-1:0] rd_idx,
  input  logic [REG_W-1:0]  rd_raw,
  output logic [REG_W-1:0]  rd_val,
  input  logic              fetch_valid,
  input  logic              fetch_sop,
  input  logic [BYTE_W-1:0] fetch_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  input  logic              flag_commit,
  input  logic [FLAG_W-1:0] flag_rd,
  output logic              flag_wb_en,
  output logic [FLAG_W-1:0] flag_wb
);
  localparam logic [TGT_W-1:0] TGT_IR   = TGT_W'(NUM_REGS);
  localparam logic [TGT_W-1:0] TGT_FLAG = TGT_W'(NUM_REGS + 1);

  logic [REG_W-1:0]  gpr_sa0 [NUM_REGS];
  logic [REG_W-1:0]  gpr_sa1 [NUM_REGS];
  logic [INSN_W-1:0] ir_sa0, ir_sa1;
  logic [FLAG_W-1:0] fl_sa0, fl_sa1;
  logic [REG_W-1:0]  sel_sa0, sel_sa1;
  logic              wb_en_d;
  logic [FLAG_W-1:0] wb_d;

  // general register mask bank; the program counter slot is tied neutral
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_gpr
    if (g == PC_IDX) begin : g_pc
      assign gpr_sa0[g] = '1;
      assign gpr_sa1[g] = '0;
    end else begin : g_slot
      sa_mask_slot #(.W(REG_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_we && (cfg_target == TGT_W'(g))),
        .kind  (cfg_kind),
        .wdata (cfg_value[REG_W-1:0]),
        .sa0_q (gpr_sa0[g]),
        .sa1_q (gpr_sa1[g])
      );
    end
  end

  sa_mask_slot #(.W(INSN_W)) u_ir_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_we && (cfg_target == TGT_IR)),
    .kind  (cfg_kind),
    .wdata (cfg_value[INSN_W-1:0]),
    .sa0_q (ir_sa0),
    .sa1_q (ir_sa1)
  );

  sa_mask_slot #(.W(FLAG_W)) u_flag_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_we && (cfg_target == TGT_FLAG)),
    .kind  (cfg_kind),
    .wdata (cfg_value[FLAG_W-1:0]),
    .sa0_q (fl_sa0),
    .sa1_q (fl_sa1)
  );

  // register read path
  always_comb begin
    sel_sa0 = '1;
    sel_sa1 = '0;
    if (int'(rd_idx) < NUM_REGS) begin
      sel_sa0 = gpr_sa0[rd_idx];
      sel_sa1 = gpr_sa1[rd_idx];
    end
  end

  assign rd_val = (rd_raw & sel_sa0) | sel_sa1;

  // byte-serial instruction path
  sa_fetch_lane #(.INSN_BYTES(INSN_BYTES)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_sop   (fetch_sop),
    .fetch_byte  (fetch_byte),
    .ir_sa0      (ir_sa0),
    .ir_sa1      (ir_sa1),
    .out_valid   (out_valid),
    .out_byte    (out_byte)
  );

  // flag write-back path
  always_comb begin
    wb_en_d = flag_commit;
    wb_d    = flag_wb;
    if (flag_commit) wb_d = (flag_rd & fl_sa0) | fl_sa1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_wb_en <= 1'b0;
      flag_wb    <= '0;
    end else begin
      flag_wb_en <= wb_en_d;
      if (flag_commit) flag_wb <= wb_d;
    end
  end

  AST_PC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) == PC_IDX) |-> (rd_val == rd_raw)); // R5
  AST_SA1_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_val & sel_sa1) == sel_sa1)); // R3
  AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_commit |=> flag_wb_en); // R8
endmodule

// File: tb/tb_sa_fault_overlay.sv
module tb_sa_fault_overlay;
  localparam int NR = 8;
  localparam int PC = 7;
  localparam int IR_T = 8;
  localparam int FL_T = 9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_kind;
  logic [3:0]  cfg_target;
  logic [31:0] cfg_value;
  logic [2:0]  rd_idx;
  logic [31:0] rd_raw, rd_val;
  logic        fetch_valid, fetch_sop, out_valid;
  logic [7:0]  fetch_byte, out_byte;
  logic        flag_commit, flag_wb_en;
  logic [31:0] flag_rd, flag_wb;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_sa0 [10];
  logic [31:0] m_sa1 [10];
  int m_idx = 0;

  always #4 clk = ~clk;

  sa_fault_overlay dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_target(cfg_target),
    .cfg_kind(cfg_kind), .cfg_value(cfg_value), .rd_idx(rd_idx), .rd_raw(rd_raw),
    .rd_val(rd_val), .fetch_valid(fetch_valid), .fetch_sop(fetch_sop),
    .fetch_byte(fetch_byte), .out_valid(out_valid), .out_byte(out_byte),
    .flag_commit(flag_commit), .flag_rd(flag_rd), .flag_wb_en(flag_wb_en),
    .flag_wb(flag_wb)
  );

  function automatic logic [31:0] exp_masked(int site, logic [31:0] v);
    return (v & m_sa0[site]) | m_sa1[site];
  endfunction

  function automatic logic [7:0] exp_byte(int k, logic [7:0] b);
    if (k >= 4) return b;
    return (b & m_sa0[IR_T][k*8 +: 8]) | m_sa1[IR_T][k*8 +: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int tgt, input bit kind, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_target = 4'(tgt); cfg_kind = kind; cfg_value = v;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (tgt < 10 && tgt != PC) begin
      if (kind) m_sa1[tgt] = v;
      else      m_sa0[tgt] = v;
    end
  endtask

  task automatic read_chk(input string req, input int idx, input logic [31:0] raw);
    @(negedge clk);
    rd_idx = 3'(idx); rd_raw = raw;
    #1;
    check(req, rd_val, exp_masked(idx, raw));
  endtask

  task automatic fetch_beat(input string req, input bit sop, input logic [7:0] b);
    int k;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_sop = sop; fetch_byte = b;
    #1;
    k = sop ? 0 : m_idx;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, {24'd0, out_byte}, {24'd0, exp_byte(k, b)});
    m_idx = (k >= 4) ? 4 : k + 1;
  endtask

  task automatic fetch_idle();
    @(negedge clk);
    fetch_valid = 1'b0; fetch_sop = 1'b0;
  endtask

  task automatic flag_chk(input string req, input logic [31:0] v);
    @(negedge clk);
    flag_commit = 1'b1; flag_rd = v;
    @(posedge clk);
    #1;
    check(req, {31'd0, flag_wb_en}, 32'd1);
    check(req, flag_wb, exp_masked(FL_T, v));
    @(negedge clk);
    flag_commit = 1'b0;
    @(posedge clk);
    #1;
    check(req, {31'd0, flag_wb_en}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 10; i++) begin m_sa0[i] = '1; m_sa1[i] = '0; end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = 1'b0; cfg_target = '0; cfg_value = '0;
    rd_idx = '0; rd_raw = '0; fetch_valid = 1'b0; fetch_sop = 1'b0; fetch_byte = '0;
    flag_commit = 1'b0; flag_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: neutral after reset
    check("R1 wb_en", {31'd0, flag_wb_en}, 32'd0);
    for (int r = 0; r < NR; r++) read_chk("R1 read", r, $urandom);
    fetch_beat("R1 fetch", 1'b1, 8'hA5);
    fetch_beat("R1 fetch", 1'b0, 8'h3C);
    fetch_idle();
    flag_chk("R1 flags", 32'hDEAD_BEEF);

    // R2 / R10: multi-bit faults on one register
    cfg_write(2, 1'b0, 32'hFFFF_00FF);
    cfg_write(2, 1'b1, 32'h0F00_0001);
    read_chk("R2 R10 read", 2, 32'hFFFF_FFFF);
    read_chk("R2 R10 read", 2, 32'h0000_0000);
    read_chk("R2 neighbour", 3, 32'h1234_5678);

    // R3: both masks on the same bit
    cfg_write(4, 1'b0, 32'hFFFF_FFFE);
    cfg_write(4, 1'b1, 32'h0000_0001);
    read_chk("R3 both", 4, 32'h0000_0000);

    // R5: program counter slot ignores writes
    cfg_write(PC, 1'b0, 32'h0000_0000);
    cfg_write(PC, 1'b1, 32'hFFFF_FFFF);
    read_chk("R5 pc", PC, 32'h8000_1234);

    // R9: out-of-range target changes nothing
    cfg_write(12, 1'b1, 32'hFFFF_FFFF);
    cfg_write(15, 1'b0, 32'h0000_0000);
    for (int r = 0; r < NR; r++) read_chk("R9 read", r, 32'h5A5A_5A5A);
    fetch_beat("R9 fetch", 1'b1, 8'h5A);
    fetch_idle();
    flag_chk("R9 flags", 32'h5A5A_5A5A);

    // R4 / R6 / R7: lane-distinct instruction masks, long and restarted streams
    cfg_write(IR_T, 1'b0, 32'hF0FF_0FFF);
    cfg_write(IR_T, 1'b1, 32'h0100_2003);
    fetch_beat("R6 b0", 1'b1, 8'hFF);
    fetch_beat("R6 b1", 1'b0, 8'h00);
    fetch_beat("R6 b2", 1'b0, 8'hFF);
    fetch_beat("R6 b3", 1'b0, 8'h00);
    fetch_beat("R7 sat", 1'b0, 8'h00);
    fetch_beat("R7 sat", 1'b0, 8'hFF);
    fetch_beat("R7 restart", 1'b1, 8'h00);
    fetch_beat("R7 mid", 1'b0, 8'hFF);
    fetch_beat("R7 restart", 1'b1, 8'hFF);
    fetch_idle();
    fetch_beat("R6 gap", 1'b0, 8'h00);
    fetch_idle();

    // R8: flag masks
    cfg_write(FL_T, 1'b0, 32'hBFFF_FFFF);
    cfg_write(FL_T, 1'b1, 32'h2000_0000);
    flag_chk("R8 flags", 32'hFFFF_FFFF);
    flag_chk("R8 flags", 32'h0000_0000);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 4);
      case (op)
        0: cfg_write(int'($urandom % 11), 1'($urandom), $urandom);
        1: read_chk("R2 rand", int'($urandom % NR), $urandom);
        2: begin
          int n = 1 + int'($urandom % 6);
          for (int b = 0; b < n; b++)
            fetch_beat("R6 R7 rand", (b == 0) || ($urandom % 8 == 0), 8'($urandom));
          fetch_idle();
        end
        default: flag_chk("R8 rand", $urandom);
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule